// File: doc/BRIEF.md
# Three-Channel Tone, Noise and Mixer

This block produces the sound-source half of a programmable sound generator. A shared divide-by-16 prescaler drives three square-wave tone generators and one noise source. Each tone generator divides the prescaled rate by its own 12-bit period. The noise source steps a 17-bit pseudo-random shift register once per 5-bit noise period. For each channel a mixer combines tone and noise under active-low enable bits. It then outputs either zero or a 4-bit amplitude. That amplitude is the channel's fixed level or an externally supplied envelope level.

The register values arrive as static configuration inputs and the block runs freely from the system clock. Each tone generator is a two-state machine with states `TONE_LOW` and `TONE_HIGH`. It takes the transition `LOW_TO_HIGH` or `HIGH_TO_LOW` on every period reload and otherwise stays in its state (`HOLD`). Reset enters `TONE_LOW`.

Top module: `psg_tone_mixer`

## Requirements
- R1: While reset is asserted, all three amplitude outputs are 0, even with every enable disabled and non-zero levels.
- R2: With only channel A's tone enabled, `amp_a` changes every 16*P clocks. P = {tone_coarse_a[3:0], tone_fine_a}, and tone_coarse_a[7:4] has no effect.
- R3: Channels B and C take their periods from {tone_coarse_b[3:0], tone_fine_b} and {tone_coarse_c[3:0], tone_fine_c}, and all three run at the same time.
- R4: A tone period of 0 gives the same 16-clock toggle interval as a period of 1.
- R5: When a running channel is given a shorter period, its next toggle comes within 16 times the new period plus one prescale interval. Each later toggle interval then equals 16 times the new period.
- R6: The noise bit steps every 16*N clocks, with N = noise_cfg[4:0] and noise_cfg[7:5] ignored. Its sequence s obeys s[0]=1, s[1..16]=0 and s[k+17]=s[k] XOR s[k+3] from reset.
- R7: mix_cfg bits 0, 1, 2 disable tone and bits 3, 4, 5 disable noise for channels A, B, C when set; bits 7:6 have no effect. A channel with both disabled outputs its level constantly.
- R8: Each channel outputs its level when (tone OR tone-disable) AND (noise OR noise-disable) is 1, and 0 otherwise.
- R9: level_cfg bit 4 set selects env_level, clear selects bits 3:0; bits 7:5 have no effect.
- R10: A change of a level input or env_level appears on the amplitude output one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_fine_a | input | 8 | Channel A period low byte |
| tone_coarse_a | input | 8 | Channel A period high nibble in bits 3:0 |
| tone_fine_b | input | 8 | Channel B period low byte |
| tone_coarse_b | input | 8 | Channel B period high nibble in bits 3:0 |
| tone_fine_c | input | 8 | Channel C period low byte |
| tone_coarse_c | input | 8 | Channel C period high nibble in bits 3:0 |
| noise_cfg | input | 8 | Noise period in bits 4:0 |
| mix_cfg | input | 8 | Active-low tone (2:0) and noise (5:3) enables |
| level_cfg_a | input | 8 | Channel A fixed level (3:0) and envelope select (4) |
| level_cfg_b | input | 8 | Channel B fixed level and envelope select |
| level_cfg_c | input | 8 | Channel C fixed level and envelope select |
| env_level | input | 4 | Level from the envelope generator |
| amp_a | output | 4 | Channel A amplitude code |
| amp_b | output | 4 | Channel B amplitude code |
| amp_c | output | 4 | Channel C amplitude code |

## Verification
The bench targets a zero period, a period that is cut short while counting, the unused upper register bits, and the exact noise bit sequence. A design that compared for an exact match would stall for a full counter wrap after a shorter period. One that treated zero literally would never toggle. The AND test holds channel A silent through the long run of zero noise bits after reset, which an OR-style mixer or an inverted enable would break. Sampling the noise every period against a software model of the shift register catches a wrong tap, seed or step rate.

// File: rtl/psg_pkg.sv
package psg_pkg;
    localparam int PRE_DIV  = 16;
    localparam int TONE_W   = 12;
    localparam int NOISE_W  = 5;
    localparam int LFSR_W   = 17;
    localparam int LFSR_TAP = 3;
    localparam int LVL_W    = 4;
    localparam int NUM_CH   = 3;
    localparam int FINE_W   = 8;
    localparam int COARSE_W = TONE_W - FINE_W;

    typedef enum logic {
        TONE_LOW  = 1'b0,
        TONE_HIGH = 1'b1
    } tone_state_t;
endpackage

// File: rtl/psg_prescale.sv
module psg_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

    always_comb tick = (cnt_q == LAST);
endmodule

// File: rtl/psg_tone_gen.sv
module psg_tone_gen
    import psg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic         tone
);
    tone_state_t state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d, period_eff;
    logic [W:0]   cnt_inc;
    logic         reload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TONE_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        period_eff = (period == '0) ? W'(1) : period;
        cnt_inc    = {1'b0, cnt_q} + 1'b1;
        reload     = tick && (cnt_inc >= {1'b0, period_eff});
        cnt_d      = cnt_q;
        state_d    = state_q;
        if (tick) cnt_d = reload ? '0 : cnt_inc[W-1:0];
        unique case (state_q)
            TONE_LOW:  if (reload) state_d = TONE_HIGH;
            TONE_HIGH: if (reload) state_d = TONE_LOW;
        endcase
    end

    always_comb tone = (state_q == TONE_HIGH);
endmodule

// File: rtl/psg_noise_gen.sv
module psg_noise_gen #(
    parameter int W   = 5,
    parameter int LW  = 17,
    parameter int TAP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [W-1:0]  period,
    output logic [LW-1:0] lfsr
);
    logic [W-1:0]  cnt_q, period_eff;
    logic [W:0]    cnt_inc;
    logic          step;

    always_comb begin
        period_eff = (period == '0) ? W'(1) : period;
        cnt_inc    = {1'b0, cnt_q} + 1'b1;
        step       = tick && (cnt_inc >= {1'b0, period_eff});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lfsr  <= LW'(1);
        end else if (tick) begin
            cnt_q <= step ? '0 : cnt_inc[W-1:0];
            if (step) lfsr <= {lfsr[0] ^ lfsr[TAP], lfsr[LW-1:1]};
        end
    end
endmodule

// File: rtl/psg_chan_mix.sv
module psg_chan_mix #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tone,
    input  logic          noise,
    input  logic          tone_off,
    input  logic          noise_off,
    input  logic [LW:0]   level_cfg,
    input  logic [LW-1:0] env_level,
    output logic [LW-1:0] amp
);
    logic          gate;
    logic [LW-1:0] level;

    always_comb begin
        gate  = (tone | tone_off) & (noise | noise_off);
        level = level_cfg[LW] ? env_level : level_cfg[LW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) amp <= '0;
        else amp <= gate ? level : '0;
    end
endmodule

// File: rtl/psg_tone_mixer.sv
module psg_tone_mixer
    import psg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       tone_fine_a,
    input  logic [7:0]       tone_coarse_a,
    input  logic [7:0]       tone_fine_b,
    input  logic [7:0]       tone_coarse_b,
    input  logic [7:0]       tone_fine_c,
    input  logic [7:0]       tone_coarse_c,
    input  logic [7:0]       noise_cfg,
    input  logic [7:0]       mix_cfg,
    input  logic [7:0]       level_cfg_a,
    input  logic [7:0]       level_cfg_b,
    input  logic [7:0]       level_cfg_c,
    input  logic [LVL_W-1:0] env_level,
    output logic [LVL_W-1:0] amp_a,
    output logic [LVL_W-1:0] amp_b,
    output logic [LVL_W-1:0] amp_c
);
    logic                pre_tick;
    logic [TONE_W-1:0]   period [NUM_CH];
    logic [LVL_W:0]      lvl    [NUM_CH];
    logic [LVL_W-1:0]    amp    [NUM_CH];
    logic [NUM_CH-1:0]   tone_bits;
    logic [LFSR_W-1:0]   noise_word;
    logic                unused_cfg_bits;

    assign period[0] = {tone_coarse_a[COARSE_W-1:0], tone_fine_a};
    assign period[1] = {tone_coarse_b[COARSE_W-1:0], tone_fine_b};
    assign period[2] = {tone_coarse_c[COARSE_W-1:0], tone_fine_c};
    assign lvl[0] = level_cfg_a[LVL_W:0];
    assign lvl[1] = level_cfg_b[LVL_W:0];
    assign lvl[2] = level_cfg_c[LVL_W:0];
    assign amp_a = amp[0];
    assign amp_b = amp[1];
    assign amp_c = amp[2];
    assign unused_cfg_bits = ^{tone_coarse_a[7:COARSE_W], tone_coarse_b[7:COARSE_W],
                               tone_coarse_c[7:COARSE_W], noise_cfg[7:NOISE_W],
                               mix_cfg[7:2*NUM_CH], level_cfg_a[7:LVL_W+1],
                               level_cfg_b[7:LVL_W+1], level_cfg_c[7:LVL_W+1]};

    psg_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(pre_tick)
    );

    psg_noise_gen #(.W(NOISE_W), .LW(LFSR_W), .TAP(LFSR_TAP)) u_noise (
        .clk(clk), .rst_n(rst_n), .tick(pre_tick),
        .period(noise_cfg[NOISE_W-1:0]), .lfsr(noise_word)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        psg_tone_gen #(.W(TONE_W)) u_tone (
            .clk(clk), .rst_n(rst_n), .tick(pre_tick),
            .period(period[ch]), .tone(tone_bits[ch])
        );
        psg_chan_mix #(.LW(LVL_W)) u_mix (
            .clk(clk), .rst_n(rst_n),
            .tone(tone_bits[ch]), .noise(noise_word[0]),
            .tone_off(mix_cfg[ch]), .noise_off(mix_cfg[NUM_CH+ch]),
            .level_cfg(lvl[ch]), .env_level(env_level), .amp(amp[ch])
        );
    end
endmodule

// File: rtl/psg_tone_mixer_chk.sv
module psg_tone_mixer_chk
    import psg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pre_tick,
    input logic [NUM_CH-1:0] tone_bits,
    input logic [LFSR_W-1:0] noise_word,
    input logic [7:0]        mix_cfg,
    input logic [7:0]        level_cfg_a,
    input logic [LVL_W-1:0]  env_level,
    input logic [LVL_W-1:0]  amp_a
);
    logic       past_ok, saw_tick;
    logic [7:0] gap_q;
    logic [LVL_W-1:0] sel_a;

    assign sel_a = level_cfg_a[LVL_W] ? env_level : level_cfg_a[LVL_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok  <= 1'b0;
            saw_tick <= 1'b0;
            gap_q    <= '0;
        end else begin
            past_ok <= 1'b1;
            if (pre_tick) begin
                saw_tick <= 1'b1;
                gap_q    <= '0;
            end else if (gap_q != 8'hFF) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (saw_tick && pre_tick) |-> (gap_q == 8'(PRE_DIV - 1))); // R2

    AST_TONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(pre_tick)) |-> $stable(tone_bits)); // R3

    AST_NOISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(pre_tick)) |-> $stable(noise_word)); // R6

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (noise_word != '0)); // R6

    AST_AMP_ZERO_OR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (amp_a == '0 || amp_a == $past(sel_a))); // R8

    AST_BOTH_OFF_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mix_cfg[0] && mix_cfg[NUM_CH])) |-> (amp_a == $past(sel_a))); // R7
endmodule

bind psg_tone_mixer psg_tone_mixer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .tone_bits(tone_bits),
    .noise_word(noise_word), .mix_cfg(mix_cfg), .level_cfg_a(level_cfg_a),
    .env_level(env_level), .amp_a(amp_a)
);

// File: tb/psg_tone_mixer_test.sv
module psg_tone_mixer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] tone_fine_a = 8'd1, tone_coarse_a = 8'd0;
    logic [7:0] tone_fine_b = 8'd1, tone_coarse_b = 8'd0;
    logic [7:0] tone_fine_c = 8'd1, tone_coarse_c = 8'd0;
    logic [7:0] noise_cfg = 8'd1, mix_cfg = 8'hFF;
    logic [7:0] level_cfg_a = 8'h0F, level_cfg_b = 8'h0F, level_cfg_c = 8'h0F;
    logic [3:0] env_level = 4'h0;
    logic [3:0] amp_a, amp_b, amp_c;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    psg_tone_mixer uut (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int amp_of(input int ch);
        return (ch == 0) ? int'(amp_a) : (ch == 1) ? int'(amp_b) : int'(amp_c);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_change(input int ch, input int limit, output int took);
        int v0 = amp_of(ch);
        took = 0;
        while (amp_of(ch) == v0 && took < limit) begin
            @(negedge clk);
            took++;
        end
    endtask

    task automatic interval(input int ch, output int gap);
        int dummy;
        wait_change(ch, 20000, dummy);
        wait_change(ch, 20000, gap);
    endtask

    task automatic t_reset();
        int g;
        mix_cfg = 8'hFF; level_cfg_a = 8'h0F; level_cfg_b = 8'h0A; level_cfg_c = 8'h05;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 amp_a in reset", amp_a, 0);
        check("R1 amp_b in reset", amp_b, 0);
        check("R1 amp_c in reset", amp_c, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 both disabled A", amp_a, 15);
        wait_change(0, 100, g);
        check("R7 amp_a constant", g, 100);
    endtask

    task automatic t_tone_a();
        int g;
        mix_cfg = 8'hFE; level_cfg_a = 8'h0F;
        tone_coarse_a = 8'hF1; tone_fine_a = 8'h00;
        do_reset();
        interval(0, g);
        check("R2 period 0x100, coarse[7:4] ignored", g, 4096);
        tone_coarse_a = 8'h00; tone_fine_a = 8'h07;
        interval(0, g);
        interval(0, g);
        check("R2 period 7", g, 112);
        tone_fine_a = 8'h00;
        interval(0, g);
        interval(0, g);
        check("R4 period 0", g, 16);
    endtask

    task automatic t_tone_bc();
        int ga, gb, gc;
        mix_cfg = 8'hF8;
        level_cfg_a = 8'h0F; level_cfg_b = 8'h0F; level_cfg_c = 8'h0F;
        tone_coarse_a = 0; tone_fine_a = 2;
        tone_coarse_b = 0; tone_fine_b = 3;
        tone_coarse_c = 0; tone_fine_c = 5;
        do_reset();
        interval(0, ga);
        interval(1, gb);
        interval(2, gc);
        check("R3 channel A interval", ga, 32);
        check("R3 channel B interval", gb, 48);
        check("R3 channel C interval", gc, 80);
    endtask

    task automatic t_period_change();
        int g;
        mix_cfg = 8'hFE; level_cfg_a = 8'h0F;
        tone_coarse_a = 0; tone_fine_a = 8'd200;
        do_reset();
        wait_change(0, 5000, g);
        repeat (500) @(negedge clk);
        tone_fine_a = 8'd3;
        wait_change(0, 5000, g);
        check("R5 first toggle soon", (g <= 64) ? 1 : 0, 1);
        wait_change(0, 5000, g);
        check("R5 new interval", g, 48);
    endtask

    task automatic t_noise(input int np);
        bit s [0:200];
        int g, bad, first_bad_act, first_bad_exp;
        for (int k = 0; k <= 16; k++) s[k] = (k == 0);
        for (int k = 17; k <= 200; k++) s[k] = s[k-17] ^ s[k-14];
        mix_cfg = 8'hF7; level_cfg_a = 8'h0F;
        noise_cfg = 8'hE0 | 8'(np);
        do_reset();
        @(negedge clk);
        check($sformatf("R6 noise seed np=%0d", np), amp_a, 15);
        wait_change(0, 2000, g);
        repeat (8 * np) @(negedge clk);
        bad = 0; first_bad_act = 0; first_bad_exp = 0;
        for (int j = 0; j < 60; j++) begin
            int e = s[1 + j] ? 15 : 0;
            if (amp_a != 4'(e) && bad == 0) begin
                first_bad_act = amp_a; first_bad_exp = e;
            end
            if (amp_a != 4'(e)) bad++;
            repeat (16 * np) @(negedge clk);
        end
        check($sformatf("R6 noise sequence np=%0d mismatches", np), bad, 0);
        if (bad != 0) check("R6 first noise mismatch", first_bad_act, first_bad_exp);
    endtask

    task automatic t_gate_and();
        int g;
        mix_cfg = 8'hF6; level_cfg_a = 8'h0F;
        tone_coarse_a = 0; tone_fine_a = 1; noise_cfg = 8'd1;
        do_reset();
        repeat (40) @(negedge clk);
        wait_change(0, 200, g);
        check("R8 noise low silences tone", g, 200);
        check("R8 amp_a zero", amp_a, 0);
    endtask

    task automatic t_levels();
        mix_cfg = 8'hFF;
        level_cfg_a = 8'hE9; level_cfg_b = 8'h10; level_cfg_c = 8'hF0;
        env_level = 4'hC;
        do_reset();
        repeat (2) @(negedge clk);
        check("R9 fixed level, bits 7:5 ignored", amp_a, 9);
        check("R9 envelope select", amp_b, 12);
        check("R9 envelope select C", amp_c, 12);
        env_level = 4'h3;
        level_cfg_a = 8'h04;
        #1;
        check("R10 old level before edge", amp_a, 9);
        @(negedge clk);
        check("R10 fixed level one clock later", amp_a, 4);
        check("R10 envelope one clock later", amp_b, 3);
    endtask

    initial begin
        t_reset();
        t_tone_a();
        t_tone_bc();
        t_period_change();
        t_noise(1);
        t_noise(2);
        t_gate_and();
        t_levels();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule